// File: doc/BRIEF.md
# PCI Delayed Configuration Write Parity Responder

This block is the target-side controller for inbound configuration writes handled as delayed transactions on a conventional PCI bus. It captures the address, data and byte-enable lines of a write data phase. It then takes the PAR line one clock later and checks even data parity before it commits to any bus termination. The check result, the phase of the transaction and a parity-error-response enable together decide the outcome. The block can retry the master with STOP#, disconnect with TRDY#, signal PERR# two clocks after such a disconnect, forward the write to the internal side, or complete a pending write and return its internal status.

A single pending entry holds the delayed write. A new write that finds the entry empty is a request-phase write. A write whose address matches the pending entry is a completion-phase retry. A write to any other address while the entry is busy is simply retried. Every detected parity error sets a sticky status flag and, unless masked, a sticky interrupt flag. Both flags are cleared only by write-one-to-clear pulses.

The controller is a Moore machine with seven states:
- IDLE: waiting for a data phase.
- CHECK: parity and decision.
- RETRY: STOP# low.
- DISC: TRDY# low, disconnect with data.
- GAP: the wait clock before PERR#.
- PERR: PERR# low.
- DONE: TRDY# low, completion.

Its transitions are:
- IDLE→CHECK on an accepted data phase.
- CHECK→RETRY, CHECK→DISC or CHECK→DONE on the decision.
- RETRY→IDLE and DONE→IDLE.
- DISC→GAP→PERR→IDLE.

Top module: `pdw_responder`

## Requirements
- R1: After a data phase is accepted (req_valid high in IDLE), neither stop_n nor trdy_n goes low in the following clock. The termination appears exactly two clocks after the data phase, once par_in has been sampled.
- R2: A parity error is flagged when the XOR of req_data, req_be and par_in (sampled one clock after the data phase) is 1, which is even parity.
- R3: A parity error on a request-phase write (no entry pending) with perr_resp_en=1 drives trdy_n low for one clock. It raises no fwd_valid and leaves the entry empty.
- R4: perr_n goes low for exactly one clock, two clocks after a parity-error disconnect on trdy_n, and at no other time.
- R5: A request-phase write with good parity, or with a parity error while perr_resp_en=0, drives stop_n low for one clock. In that same clock it pulses fwd_valid with the captured address, data and byte enables on fwd_addr, fwd_data and fwd_be, and the entry becomes pending.
- R6: Every detected parity error sets det_perr, which stays set until cleared.
- R7: On a parity error int_perr is set if perr_int_mask=0; with perr_int_mask=1 it is left unchanged.
- R8: clr_det clears det_perr and clr_int clears int_perr one clock later. A parity error in the same clock as clr_det leaves det_perr set.
- R9: While an entry is pending, a write to a different address is retried with stop_n, with no fwd_valid, no perr_n and no change to the entry.
- R10: A completion-phase retry (same address as the pending entry) with a parity error is disconnected on trdy_n, followed by perr_n as in R4, when perr_resp_en=1. It is retried on stop_n when perr_resp_en=0. In both cases the entry is kept.
- R11: A completion-phase retry with good parity and matching data and byte enables, after int_done has returned, is completed with trdy_n low. During that clock cpl_err equals the int_err value returned, and the entry is freed.
- R12: A completion-phase retry with good parity that arrives before int_done, or whose data or byte enables differ from the entry, is retried on stop_n and the entry is kept.
- R13: An int_done pulse while no entry is pending, or after the pending entry has already received its status, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write data phase presented this clock |
| req_addr | input | AW | Configuration write address |
| req_data | input | DW | Write data (AD lines) |
| req_be | input | BEW | Byte-enable lines as driven on the bus |
| par_in | input | 1 | PAR line, valid one clock after the data phase |
| perr_resp_en | input | 1 | Parity error response enable |
| perr_int_mask | input | 1 | Masks setting of int_perr |
| clr_det | input | 1 | Write-one-to-clear for det_perr |
| clr_int | input | 1 | Write-one-to-clear for int_perr |
| int_done | input | 1 | Internal side returned status for the pending write |
| int_err | input | 1 | Internal completion status, 1 = error |
| stop_n | output | 1 | Retry termination, active low |
| trdy_n | output | 1 | Disconnect or completion with data, active low |
| perr_n | output | 1 | Data parity error signal, active low |
| fwd_valid | output | 1 | One-clock pulse forwarding a write to the internal side |
| fwd_addr | output | AW | Forwarded address |
| fwd_data | output | DW | Forwarded data |
| fwd_be | output | BEW | Forwarded byte enables |
| cpl_err | output | 1 | Internal status returned during a completion |
| det_perr | output | 1 | Sticky detected-parity-error flag |
| int_perr | output | 1 | Sticky interrupt copy of the parity error flag |

## Verification
The assertions assume three things about the inputs. A new data phase is presented only while the controller is idle, par_in belongs to the phase accepted one clock earlier, and perr_resp_en is steady between acceptance and the end of the PERR# window. The stimulus meets these assumptions by issuing each write through one task. That task drives the data phase, drives PAR on the next clock and waits out the whole termination and PERR# window before the next operation starts. Random addresses and data are drawn from two-value pools so that completion-phase matches, data mismatches and foreign addresses all occur often. Parity errors, response-enable and mask settings, internal completions and clear pulses are interleaved between writes.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_RETRY = 3'd2,
        S_DISC  = 3'd3,
        S_GAP   = 3'd4,
        S_PERR  = 3'd5,
        S_DONE  = 3'd6
    } pdw_state_e;

endpackage

// File: rtl/pdw_parity.sv
module pdw_parity #(
    parameter int   DW  = 32,
    parameter int   BEW = DW / 8,
    parameter logic ODD = 1'b0
) (
    input  logic [DW-1:0]  data_i,
    input  logic [BEW-1:0] be_i,
    input  logic           par_i,
    output logic           err_o
);
    logic sum;

    always_comb sum = ^{data_i, be_i, par_i};

    generate
        if (ODD) begin : g_odd
            always_comb err_o = ~sum;
        end else begin : g_even
            always_comb err_o = sum;
        end
    endgenerate
endmodule

// File: rtl/pdw_queue.sv
module pdw_queue #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push_i,
    input  logic [AW-1:0]  push_addr_i,
    input  logic [DW-1:0]  push_data_i,
    input  logic [BEW-1:0] push_be_i,
    input  logic           pop_i,
    input  logic           done_i,
    input  logic           done_err_i,
    output logic           valid_o,
    output logic           done_o,
    output logic           err_o,
    output logic [AW-1:0]  addr_o,
    output logic [DW-1:0]  data_o,
    output logic [BEW-1:0] be_o
);
    logic           valid_q, done_q, err_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic [BEW-1:0] be_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            be_q    <= '0;
        end else if (push_i) begin
            valid_q <= 1'b1;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= push_addr_i;
            data_q  <= push_data_i;
            be_q    <= push_be_i;
        end else if (pop_i) begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else if (done_i && valid_q && !done_q) begin
            done_q  <= 1'b1;
            err_q   <= done_err_i;
        end
    end

    assign valid_o = valid_q;
    assign done_o  = done_q;
    assign err_o   = err_q;
    assign addr_o  = addr_q;
    assign data_o  = data_q;
    assign be_o    = be_q;

    // R5: a write is only enqueued into an empty slot
    a_r5_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !valid_q);
    // R11: an entry is freed only after its internal status came back
    a_r11_pop_ready: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (valid_q && done_q));
    // R13: completion status is frozen once captured
    a_r13_status_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !push_i && !pop_i) |=> (done_q && $stable(err_q)));
endmodule

// File: rtl/pdw_status.sv
module pdw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic mask_i,
    input  logic clr_det_i,
    input  logic clr_int_i,
    output logic det_o,
    output logic irq_o
);
    logic det_q, irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (evt_i)          det_q <= 1'b1;
            else if (clr_det_i) det_q <= 1'b0;
            if (evt_i && !mask_i) irq_q <= 1'b1;
            else if (clr_int_i)   irq_q <= 1'b0;
        end
    end

    assign det_o = det_q;
    assign irq_o = irq_q;

    // R6: detected flag is sticky without a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && !clr_det_i) |=> det_q);
    // R8: an error event beats a simultaneous clear
    a_r8_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> det_q);
    // R7: a masked event cannot raise the interrupt flag
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_q && (!evt_i || mask_i)) |=> !irq_q);
endmodule

// File: rtl/pdw_responder.sv
module pdw_responder #(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_data,
    input  logic [BEW-1:0] req_be,
    input  logic           par_in,
    input  logic           perr_resp_en,
    input  logic           perr_int_mask,
    input  logic           clr_det,
    input  logic           clr_int,
    input  logic           int_done,
    input  logic           int_err,
    output logic           stop_n,
    output logic           trdy_n,
    output logic           perr_n,
    output logic           fwd_valid,
    output logic [AW-1:0]  fwd_addr,
    output logic [DW-1:0]  fwd_data,
    output logic [BEW-1:0] fwd_be,
    output logic           cpl_err,
    output logic           det_perr,
    output logic           int_perr
);
    import pdw_pkg::*;

    pdw_state_e st_q, st_d;

    logic [AW-1:0]  lat_addr;
    logic [DW-1:0]  lat_data;
    logic [BEW-1:0] lat_be;
    logic           accept, checking, par_err;
    logic           q_valid, q_done, q_err;
    logic [AW-1:0]  q_addr;
    logic [DW-1:0]  q_data;
    logic [BEW-1:0] q_be;
    logic           hit, same, push, pop;
    logic           fwd_q, cpl_q;

    assign accept   = (st_q == S_IDLE) && req_valid;
    assign checking = (st_q == S_CHECK);

    // capture of the data phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_data <= '0;
            lat_be   <= '0;
        end else if (accept) begin
            lat_addr <= req_addr;
            lat_data <= req_data;
            lat_be   <= req_be;
        end
    end

    pdw_parity #(.DW(DW), .BEW(BEW), .ODD(1'b0)) u_parity (
        .data_i (lat_data),
        .be_i   (lat_be),
        .par_i  (par_in),
        .err_o  (par_err)
    );

    pdw_queue #(.AW(AW), .DW(DW), .BEW(BEW)) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_addr_i (lat_addr),
        .push_data_i (lat_data),
        .push_be_i   (lat_be),
        .pop_i       (pop),
        .done_i      (int_done),
        .done_err_i  (int_err),
        .valid_o     (q_valid),
        .done_o      (q_done),
        .err_o       (q_err),
        .addr_o      (q_addr),
        .data_o      (q_data),
        .be_o        (q_be)
    );

    pdw_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (checking && par_err),
        .mask_i    (perr_int_mask),
        .clr_det_i (clr_det),
        .clr_int_i (clr_int),
        .det_o     (det_perr),
        .irq_o     (int_perr)
    );

    assign hit  = q_valid && (lat_addr == q_addr);
    assign same = hit && (lat_data == q_data) && (lat_be == q_be);

    // next state and queue actions
    always_comb begin
        st_d = st_q;
        push = 1'b0;
        pop  = 1'b0;
        unique case (st_q)
            S_IDLE:  if (req_valid) st_d = S_CHECK;
            S_CHECK: begin
                if (!q_valid) begin
                    if (par_err && perr_resp_en) begin
                        st_d = S_DISC;
                    end else begin
                        st_d = S_RETRY;
                        push = 1'b1;
                    end
                end else if (!hit) begin
                    st_d = S_RETRY;
                end else if (par_err) begin
                    st_d = perr_resp_en ? S_DISC : S_RETRY;
                end else if (same && q_done) begin
                    st_d = S_DONE;
                    pop  = 1'b1;
                end else begin
                    st_d = S_RETRY;
                end
            end
            S_RETRY: st_d = S_IDLE;
            S_DISC:  st_d = S_GAP;
            S_GAP:   st_d = S_PERR;
            S_PERR:  st_d = S_IDLE;
            S_DONE:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_q <= 1'b0;
            cpl_q <= 1'b0;
        end else begin
            fwd_q <= push;
            if (pop) cpl_q <= q_err;
        end
    end

    // outputs
    always_comb begin
        stop_n  = 1'b1;
        trdy_n  = 1'b1;
        perr_n  = 1'b1;
        cpl_err = 1'b0;
        unique case (st_q)
            S_RETRY: stop_n = 1'b0;
            S_DISC:  trdy_n = 1'b0;
            S_PERR:  perr_n = 1'b0;
            S_DONE: begin
                trdy_n  = 1'b0;
                cpl_err = cpl_q;
            end
            default: ;
        endcase
    end

    assign fwd_valid = fwd_q;
    assign fwd_addr  = q_addr;
    assign fwd_data  = q_data;
    assign fwd_be    = q_be;

    // R1: no termination in the clock that samples PAR
    a_r1_hold_term: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (stop_n && trdy_n));
    // R4: PERR# two clocks after a parity disconnect
    a_r4_perr_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_DISC) |=> ##1 !perr_n);
    // R4: at most one termination signal at a time
    a_r4_onehot_term: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~stop_n, ~trdy_n, ~perr_n}));
    // R5: forwarding only goes with a retry
    a_r5_fwd_retry: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !stop_n);
    // R3: a disconnect never forwards
    a_r3_no_fwd_disc: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !fwd_valid);
    // R10: with response disabled, no PERR# follows a check
    a_r10_no_perr_dis: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && !perr_resp_en) |=> ##2 perr_n);
endmodule

// File: tb/pdw_responder_test.sv
`timescale 1ns/1ps
module pdw_responder_test;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, req_valid, par_in, perr_resp_en, perr_int_mask;
    logic clr_det, clr_int, int_done, int_err;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_data;
    logic [BW-1:0] req_be;
    logic stop_n, trdy_n, perr_n, fwd_valid, cpl_err, det_perr, int_perr;
    logic [AW-1:0] fwd_addr;
    logic [DW-1:0] fwd_data;
    logic [BW-1:0] fwd_be;

    pdw_responder #(.AW(AW), .DW(DW), .BEW(BW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_be(req_be), .par_in(par_in),
        .perr_resp_en(perr_resp_en), .perr_int_mask(perr_int_mask),
        .clr_det(clr_det), .clr_int(clr_int), .int_done(int_done), .int_err(int_err),
        .stop_n(stop_n), .trdy_n(trdy_n), .perr_n(perr_n), .fwd_valid(fwd_valid),
        .fwd_addr(fwd_addr), .fwd_data(fwd_data), .fwd_be(fwd_be),
        .cpl_err(cpl_err), .det_perr(det_perr), .int_perr(int_perr)
    );

    int total = 0;
    int bad   = 0;

    // reference model state
    bit            mqv, mdone, merr, mdet, mint;
    logic [AW-1:0] mqa;
    logic [DW-1:0] mqd;
    logic [BW-1:0] mqb;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // even parity bit for a data phase (R2)
    function automatic logic good_par(input logic [DW-1:0] d, input logic [BW-1:0] b);
        return ^{d, b};
    endfunction

    // kind: 0 = retry, 1 = disconnect, 2 = completion
    task automatic transact(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic [BW-1:0] b, input bit berr, input bit en,
                            input bit clr);
        int    kind;
        bit    push, pop, cerr;
        string rq;
        push = 0; pop = 0; cerr = 0;
        if (!mqv) begin
            if (berr && en) begin kind = 1; rq = "R3"; end
            else begin kind = 0; push = 1; rq = "R5"; end
        end else if (a != mqa) begin
            kind = 0; rq = "R9";
        end else if (berr) begin
            kind = en ? 1 : 0; rq = "R10";
        end else if (d == mqd && b == mqb && mdone) begin
            kind = 2; pop = 1; cerr = merr; rq = "R11";
        end else begin
            kind = 0; rq = "R12";
        end
        if (berr) begin
            mdet = 1;
            if (!perr_int_mask) mint = 1;
        end else if (clr) begin
            mdet = 0;
        end

        @(negedge clk);
        req_valid = 1; req_addr = a; req_data = d; req_be = b; perr_resp_en = en;
        @(negedge clk);
        req_valid = 0;
        par_in = good_par(d, b) ^ berr;   // R2: flipped PAR gives an error
        clr_det = clr;
        chk(stop_n && trdy_n, "R1", "no early termination", {stop_n, trdy_n}, 2'b11);
        @(negedge clk);
        clr_det = 0; par_in = 0;
        chk(stop_n == (kind != 0), rq, "stop_n", stop_n, kind != 0);
        chk(trdy_n == (kind == 0), rq, "trdy_n", trdy_n, kind == 0);
        chk(perr_n == 1'b1, "R4", "perr_n early", perr_n, 1);
        chk(fwd_valid == push, rq, "fwd_valid", fwd_valid, push);
        if (push)
            chk(fwd_addr == a && fwd_data == d && fwd_be == b, "R5", "fwd fields",
                {fwd_addr, fwd_data}, {a, d});
        if (kind == 2)
            chk(cpl_err == cerr, "R11", "cpl_err", cpl_err, cerr);
        chk(det_perr == mdet, berr ? "R6 (R2 parity)" : "R8", "det_perr", det_perr, mdet);
        chk(int_perr == mint, "R7", "int_perr", int_perr, mint);
        if (push) begin
            mqv = 1; mdone = 0; merr = 0; mqa = a; mqd = d; mqb = b;
        end
        if (pop) mqv = 0;
        @(negedge clk);
        chk(stop_n && trdy_n && perr_n, "R4", "idle gap", {stop_n, trdy_n, perr_n}, 3'b111);
        @(negedge clk);
        chk(perr_n == (kind != 1), "R4", "perr_n window", perr_n, kind != 1);
        if (kind == 1) begin
            @(negedge clk);
            chk(perr_n == 1'b1, "R4", "perr_n single clock", perr_n, 1);
        end
    endtask

    task automatic complete(input bit e);
        @(negedge clk);
        int_done = 1; int_err = e;
        @(negedge clk);
        int_done = 0; int_err = 0;
        if (mqv && !mdone) begin mdone = 1; merr = e; end  // R13 otherwise ignored
    endtask

    task automatic clear(input bit cd, input bit ci);
        @(negedge clk);
        clr_det = cd; clr_int = ci;
        @(negedge clk);
        clr_det = 0; clr_int = 0;
        if (cd) mdet = 0;
        if (ci) mint = 0;
        chk(det_perr == mdet, "R8", "det after clear", det_perr, mdet);
        chk(int_perr == mint, "R8", "int after clear", int_perr, mint);
    endtask

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    localparam logic [AW-1:0] A0 = 32'h0000_0040;
    localparam logic [AW-1:0] A1 = 32'h0000_0084;
    localparam logic [DW-1:0] D0 = 32'h1234_5678;
    localparam logic [DW-1:0] D1 = 32'hCAFE_0013;

    initial begin
        void'($urandom(32'd20071));
        rst_n = 0; req_valid = 0; par_in = 0; perr_resp_en = 0; perr_int_mask = 0;
        clr_det = 0; clr_int = 0; int_done = 0; int_err = 0;
        req_addr = '0; req_data = '0; req_be = '0;
        mqv = 0; mdone = 0; merr = 0; mdet = 0; mint = 0; mqa = '0; mqd = '0; mqb = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(stop_n && trdy_n && perr_n && !fwd_valid, "R1", "reset outputs",
            {stop_n, trdy_n, perr_n, fwd_valid}, 4'b1110);
        chk(!det_perr && !int_perr, "R6", "reset flags", {det_perr, int_perr}, 0);

        // R13: stray completion with nothing pending
        complete(1'b1);
        transact(A0, D0, 4'hF, 0, 1, 0);   // R5 enqueue
        transact(A0, D0, 4'hF, 0, 1, 0);   // R12 before internal done
        complete(1'b0);
        complete(1'b1);                    // R13 second status ignored
        transact(A0, D1, 4'hF, 0, 1, 0);   // R12 data mismatch
        transact(A1, D0, 4'hF, 0, 1, 0);   // R9 foreign address
        transact(A1, D0, 4'hF, 1, 1, 0);   // R9 foreign address with bad parity
        transact(A0, D0, 4'hF, 1, 1, 0);   // R10 enabled: disconnect + PERR#
        transact(A0, D0, 4'hF, 1, 0, 0);   // R10 disabled: retry
        transact(A0, D0, 4'hF, 0, 1, 0);   // R11 completes, cpl_err=0
        transact(A1, D1, 4'h3, 1, 1, 0);   // R3 request-phase disconnect
        transact(A1, D1, 4'h3, 1, 0, 0);   // R5 bad parity, response off: enqueue
        complete(1'b1);
        transact(A1, D1, 4'h3, 0, 1, 0);   // R11 cpl_err=1
        clear(1, 1);
        perr_int_mask = 1;
        transact(A0, D0, 4'hF, 1, 1, 0);   // R7 masked
        clear(1, 0);
        transact(A0, D1, 4'hF, 1, 1, 1);   // R8 event beats clear
        perr_int_mask = 0;

        for (int i = 0; i < 400; i++) begin
            int op;
            op = $urandom % 10;
            perr_int_mask = ($urandom % 3) == 0;
            if (op < 7)
                transact(($urandom % 2) ? A0 : A1, ($urandom % 2) ? D0 : D1,
                         ($urandom % 4) ? 4'hF : 4'h5, ($urandom % 4) == 0,
                         $urandom % 2, ($urandom % 8) == 0);
            else if (op == 7) complete($urandom % 2);
            else if (op == 8) clear($urandom % 2, $urandom % 2);
            else repeat (2) @(negedge clk);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule